// File: doc/BRIEF.md
# Operand Bypass and Hazard Control Unit

This block sits beside the latches of an in-order, five-stage integer pipeline with a 32-entry register file. It decides every cycle where the execute-stage instruction gets its operands from. The choices are the value read from the register file, the result held in the execute/memory latch, or the result held in the memory/writeback latch. It delivers the two ALU operands and, separately, the store-data value. The register file, ALU, memories and the latches themselves live outside the unit.

The same unit also controls pipeline flow. A load in execute whose destination feeds the instruction in decode causes a one-cycle interlock. During that cycle the program counter and the fetch/decode latch hold, and a bubble with all control bits cleared enters the decode/execute latch. On the next cycle the loaded value arrives through the memory/writeback bypass. A redirect from branch resolution clears both the fetch/decode and decode/execute latches, and it overrides any interlock raised in the same cycle.

Every output is combinational in the inputs. Two small state-like decisions are encoded as enumerations. Each operand source is one of `SRC_REG`, `SRC_EXMEM` or `SRC_MEMWB`. The flow action is one of three:
- `ACT_RUN`: no hazard.
- `ACT_INTERLOCK`: load-use stall.
- `ACT_FLUSH`: redirect.

Transitions between them follow directly from the current inputs: redirect selects `ACT_FLUSH`, otherwise a load-use hit selects `ACT_INTERLOCK`, otherwise `ACT_RUN`. Operand source moves to `SRC_EXMEM` on an execute/memory hit, otherwise to `SRC_MEMWB` on a memory/writeback hit, otherwise stays `SRC_REG`.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When the execute/memory latch has its write flag set, a nonzero destination, and a destination equal to an execute-stage source index, that operand takes the execute/memory result.
- R2: When only the memory/writeback latch qualifies under the same three conditions, the operand takes the memory/writeback result.
- R3: When both latches qualify for the same source, the execute/memory result is used.
- R4: A source index of 0 is never bypassed; the operand equals the register-file value supplied for it.
- R5: A latch whose write flag is clear is never a bypass source, even if its destination matches.
- R6: When the immediate-select input is 1, the second ALU operand equals the immediate input regardless of any match.
- R7: Store data is the bypassed value of the second source, chosen by R1 to R5, independent of the immediate-select input.
- R8: When the execute-stage load flag is 1 and its nonzero destination equals either decode-stage source, stall and bubble are both 1 and both flushes are 0; otherwise, without a redirect, stall and bubble are 0.
- R9: A load whose destination is 0 never raises stall or bubble.
- R10: When redirect is 1, both flush outputs are 1 and stall and bubble are 0, even when R8 would stall.
- R11: A matching destination on a non-load execute-stage instruction raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index of the decode-stage instruction |
| id_rs2 | input | 5 | Second source index of the decode-stage instruction |
| ex_rs1 | input | 5 | First source index of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source index of the execute-stage instruction |
| ex_rs1_val | input | 32 | Register-file value carried for the first source |
| ex_rs2_val | input | 32 | Register-file value carried for the second source |
| ex_imm | input | 32 | Immediate of the execute-stage instruction |
| ex_use_imm | input | 1 | 1 selects the immediate as second ALU operand |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| em_rd | input | 5 | Destination index in the execute/memory latch |
| em_wen | input | 1 | Register-write flag in the execute/memory latch |
| em_res | input | 32 | ALU result in the execute/memory latch |
| mw_rd | input | 5 | Destination index in the memory/writeback latch |
| mw_wen | input | 1 | Register-write flag in the memory/writeback latch |
| mw_res | input | 32 | ALU or load result in the memory/writeback latch |
| redirect | input | 1 | Branch resolution requests a redirect |
| alu_a | output | 32 | First ALU operand |
| alu_b | output | 32 | Second ALU operand |
| store_data | output | 32 | Data to be written by a store |
| stall_fetch | output | 1 | Hold PC and fetch/decode latch |
| bubble_idex | output | 1 | Load a cleared bubble into decode/execute latch |
| flush_ifid | output | 1 | Clear the fetch/decode latch |
| flush_idex | output | 1 | Clear the decode/execute latch |

## Verification
A wrong source selection shows up in the same cycle as an operand or store-data value that equals the wrong input word. Because the three candidate words differ, the mistake is unambiguous. A wrong flow action appears at once on the stall, bubble or flush lines, most tellingly when a redirect coincides with a load-use hit. Since nothing is registered, every error is visible in the very cycle its inputs are applied. None can hide and surface later.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } byp_src_e;

    typedef enum logic [1:0] {
        ACT_RUN       = 2'd0,
        ACT_INTERLOCK = 2'd1,
        ACT_FLUSH     = 2'd2
    } haz_act_e;

endpackage

// File: rtl/byp_select.sv
module byp_select
    import fwd_pkg::*;
#(
    parameter int REGW = 5
) (
    input  logic [REGW-1:0] src_idx,
    input  logic [REGW-1:0] em_rd,
    input  logic            em_wen,
    input  logic [REGW-1:0] mw_rd,
    input  logic            mw_wen,
    output byp_src_e        sel
);

    logic src_live;
    logic em_hit;
    logic mw_hit;

    // x0 is hardwired, so it never consumes a bypass
    assign src_live = (src_idx != '0);
    assign em_hit   = src_live && em_wen && (em_rd == src_idx);
    assign mw_hit   = src_live && mw_wen && (mw_rd == src_idx);

    always_comb begin
        if (em_hit)
            sel = SRC_EXMEM;
        else if (mw_hit)
            sel = SRC_MEMWB;
        else
            sel = SRC_REG;
    end

    always_comb begin
        if (em_wen && mw_wen && (em_rd == mw_rd) && (em_rd == src_idx) && (src_idx != '0))
            AST_YOUNGER_WINS: assert (sel == SRC_EXMEM); // R3
        if (!em_wen && !mw_wen)
            AST_NO_WEN_NO_BYP: assert (sel == SRC_REG); // R5
    end

endmodule

// File: rtl/byp_mux.sv
module byp_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  byp_src_e        sel,
    input  logic [XLEN-1:0] reg_val,
    input  logic [XLEN-1:0] em_res,
    input  logic [XLEN-1:0] mw_res,
    output logic [XLEN-1:0] val
);

    always_comb begin
        unique case (sel)
            SRC_EXMEM: val = em_res;
            SRC_MEMWB: val = mw_res;
            default:   val = reg_val;
        endcase
    end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import fwd_pkg::*;
#(
    parameter int REGW = 5
) (
    input  logic [REGW-1:0] id_rs1,
    input  logic [REGW-1:0] id_rs2,
    input  logic            ex_is_load,
    input  logic [REGW-1:0] ex_rd,
    input  logic            redirect,
    output logic            stall_fetch,
    output logic            bubble_idex,
    output logic            flush_ifid,
    output logic            flush_idex
);

    haz_act_e act;
    logic     load_dep;

    assign load_dep = ex_is_load && (ex_rd != '0) &&
                      ((ex_rd == id_rs1) || (ex_rd == id_rs2));

    // action selection: flush outranks interlock
    always_comb begin
        if (redirect)
            act = ACT_FLUSH;
        else if (load_dep)
            act = ACT_INTERLOCK;
        else
            act = ACT_RUN;
    end

    // outputs per action
    always_comb begin
        stall_fetch = 1'b0;
        bubble_idex = 1'b0;
        flush_ifid  = 1'b0;
        flush_idex  = 1'b0;
        unique case (act)
            ACT_INTERLOCK: begin
                stall_fetch = 1'b1;
                bubble_idex = 1'b1;
            end
            ACT_FLUSH: begin
                flush_ifid = 1'b1;
                flush_idex = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (stall_fetch)
            AST_STALL_NEEDS_LOAD: assert (ex_is_load && ex_rd != '0); // R9
        if (ex_is_load && ex_rd != '0 && ex_rd == id_rs1 && !redirect)
            AST_LOAD_USE_STALLS: assert (stall_fetch && bubble_idex); // R8
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic [$clog2(NREG)-1:0] id_rs1,
    input  logic [$clog2(NREG)-1:0] id_rs2,
    input  logic [$clog2(NREG)-1:0] ex_rs1,
    input  logic [$clog2(NREG)-1:0] ex_rs2,
    input  logic [XLEN-1:0]         ex_rs1_val,
    input  logic [XLEN-1:0]         ex_rs2_val,
    input  logic [XLEN-1:0]         ex_imm,
    input  logic                    ex_use_imm,
    input  logic                    ex_is_load,
    input  logic [$clog2(NREG)-1:0] ex_rd,
    input  logic [$clog2(NREG)-1:0] em_rd,
    input  logic                    em_wen,
    input  logic [XLEN-1:0]         em_res,
    input  logic [$clog2(NREG)-1:0] mw_rd,
    input  logic                    mw_wen,
    input  logic [XLEN-1:0]         mw_res,
    input  logic                    redirect,
    output logic [XLEN-1:0]         alu_a,
    output logic [XLEN-1:0]         alu_b,
    output logic [XLEN-1:0]         store_data,
    output logic                    stall_fetch,
    output logic                    bubble_idex,
    output logic                    flush_ifid,
    output logic                    flush_idex
);

    localparam int REGW    = $clog2(NREG);
    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][REGW-1:0] op_idx;
    logic [NUM_OPS-1:0][XLEN-1:0] op_reg;
    logic [NUM_OPS-1:0][XLEN-1:0] op_byp;
    byp_src_e                     op_sel [NUM_OPS];

    assign op_idx[0] = ex_rs1;
    assign op_idx[1] = ex_rs2;
    assign op_reg[0] = ex_rs1_val;
    assign op_reg[1] = ex_rs2_val;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        byp_select #(.REGW(REGW)) u_sel (
            .src_idx (op_idx[g]),
            .em_rd   (em_rd),
            .em_wen  (em_wen),
            .mw_rd   (mw_rd),
            .mw_wen  (mw_wen),
            .sel     (op_sel[g])
        );
        byp_mux #(.XLEN(XLEN)) u_mux (
            .sel     (op_sel[g]),
            .reg_val (op_reg[g]),
            .em_res  (em_res),
            .mw_res  (mw_res),
            .val     (op_byp[g])
        );
    end

    assign alu_a      = op_byp[0];
    assign store_data = op_byp[1];
    assign alu_b      = ex_use_imm ? ex_imm : op_byp[1];

    hazard_ctl #(.REGW(REGW)) u_haz (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .ex_is_load  (ex_is_load),
        .ex_rd       (ex_rd),
        .redirect    (redirect),
        .stall_fetch (stall_fetch),
        .bubble_idex (bubble_idex),
        .flush_ifid  (flush_ifid),
        .flush_idex  (flush_idex)
    );

    always_comb begin
        AST_A_FROM_CANDIDATE: assert (alu_a == ex_rs1_val || alu_a == em_res || alu_a == mw_res); // R1
        if (ex_rs1 == '0)
            AST_X0_A_UNBYPASSED: assert (alu_a == ex_rs1_val); // R4
        if (ex_rs2 == '0)
            AST_X0_ST_UNBYPASSED: assert (store_data == ex_rs2_val); // R4
        if (ex_use_imm)
            AST_IMM_ON_B: assert (alu_b == ex_imm); // R6
        if (!ex_use_imm)
            AST_B_MATCHES_STORE: assert (alu_b == store_data); // R7
        if (redirect)
            AST_FLUSH_OVERRIDES: assert (flush_ifid && flush_idex && !stall_fetch && !bubble_idex); // R10
        AST_STALL_PAIRS_BUBBLE: assert (stall_fetch == bubble_idex); // R8
    end

endmodule

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [4:0]  id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, em_rd, mw_rd;
    logic [31:0] ex_rs1_val, ex_rs2_val, ex_imm, em_res, mw_res;
    logic        ex_use_imm, ex_is_load, em_wen, mw_wen, redirect;
    logic [31:0] alu_a, alu_b, store_data;
    logic        stall_fetch, bubble_idex, flush_ifid, flush_idex;

    int total = 0;
    int bad   = 0;

    fwd_hazard_unit dut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rs1_val(ex_rs1_val), .ex_rs2_val(ex_rs2_val), .ex_imm(ex_imm),
        .ex_use_imm(ex_use_imm), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .em_rd(em_rd), .em_wen(em_wen), .em_res(em_res),
        .mw_rd(mw_rd), .mw_wen(mw_wen), .mw_res(mw_res),
        .redirect(redirect),
        .alu_a(alu_a), .alu_b(alu_b), .store_data(store_data),
        .stall_fetch(stall_fetch), .bubble_idex(bubble_idex),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_opnd(input logic [4:0] src, input logic [31:0] rv);
        if (src != 0 && em_wen && em_rd == src) return em_res;
        if (src != 0 && mw_wen && mw_rd == src) return mw_res;
        return rv;
    endfunction

    function automatic logic exp_stall();
        if (redirect) return 1'b0;
        return ex_is_load && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; em_rd = 0; mw_rd = 0;
        ex_rs1_val = 32'h1111_0001; ex_rs2_val = 32'h2222_0002; ex_imm = 32'h3333_0003;
        em_res = 32'h4444_0004; mw_res = 32'h5555_0005;
        ex_use_imm = 0; ex_is_load = 0; em_wen = 0; mw_wen = 0; redirect = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic full_check(input string tag);
        chk({tag, " R1 alu_a"}, alu_a, exp_opnd(ex_rs1, ex_rs1_val));
        chk({tag, " R6 alu_b"}, alu_b, ex_use_imm ? ex_imm : exp_opnd(ex_rs2, ex_rs2_val));
        chk({tag, " R7 store"}, store_data, exp_opnd(ex_rs2, ex_rs2_val));
        chk({tag, " R8 stall"}, {31'd0, stall_fetch}, {31'd0, exp_stall()});
        chk({tag, " R8 bubble"}, {31'd0, bubble_idex}, {31'd0, exp_stall()});
        chk({tag, " R10 flush_ifid"}, {31'd0, flush_ifid}, {31'd0, redirect});
        chk({tag, " R10 flush_idex"}, {31'd0, flush_idex}, {31'd0, redirect});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // reset/idle state
        settle();
        chk("idle R4 alu_a", alu_a, 32'h1111_0001);
        chk("idle R8 stall", {31'd0, stall_fetch}, 32'd0);
        chk("idle R10 flush", {31'd0, flush_ifid}, 32'd0);

        // R1: execute/memory hit on first source
        idle(); ex_rs1 = 5'd7; em_rd = 5'd7; em_wen = 1; settle();
        chk("R1 em hit", alu_a, 32'h4444_0004);

        // R2: memory/writeback hit on second source
        idle(); ex_rs2 = 5'd9; mw_rd = 5'd9; mw_wen = 1; settle();
        chk("R2 mw hit b", alu_b, 32'h5555_0005);
        chk("R2 mw hit store", store_data, 32'h5555_0005);

        // R3: both match
        idle(); ex_rs1 = 5'd3; em_rd = 5'd3; mw_rd = 5'd3; em_wen = 1; mw_wen = 1; settle();
        chk("R3 priority", alu_a, 32'h4444_0004);

        // R4: x0 never bypassed
        idle(); em_wen = 1; mw_wen = 1; settle();
        chk("R4 x0 a", alu_a, 32'h1111_0001);
        chk("R4 x0 store", store_data, 32'h2222_0002);

        // R5: write flag clear
        idle(); ex_rs1 = 5'd5; em_rd = 5'd5; mw_rd = 5'd5; settle();
        chk("R5 no wen", alu_a, 32'h1111_0001);

        // R6 and R7: immediate does not suppress store bypass
        idle(); ex_rs2 = 5'd12; em_rd = 5'd12; em_wen = 1; ex_use_imm = 1; settle();
        chk("R6 imm b", alu_b, 32'h3333_0003);
        chk("R7 store byp", store_data, 32'h4444_0004);

        // R8: load-use on second decode source
        idle(); ex_is_load = 1; ex_rd = 5'd14; id_rs2 = 5'd14; settle();
        chk("R8 stall", {31'd0, stall_fetch}, 32'd1);
        chk("R8 bubble", {31'd0, bubble_idex}, 32'd1);
        chk("R8 no flush", {31'd0, flush_idex}, 32'd0);

        // R9: load to x0
        idle(); ex_is_load = 1; ex_rd = 5'd0; settle();
        chk("R9 x0 load", {31'd0, stall_fetch}, 32'd0);

        // R11: non-load match
        idle(); ex_rd = 5'd6; id_rs1 = 5'd6; settle();
        chk("R11 alu dep", {31'd0, stall_fetch}, 32'd0);

        // R10: redirect with simultaneous load-use
        idle(); ex_is_load = 1; ex_rd = 5'd8; id_rs1 = 5'd8; redirect = 1; settle();
        chk("R10 flush_ifid", {31'd0, flush_ifid}, 32'd1);
        chk("R10 flush_idex", {31'd0, flush_idex}, 32'd1);
        chk("R10 no stall", {31'd0, stall_fetch}, 32'd0);
        chk("R10 no bubble", {31'd0, bubble_idex}, 32'd0);

        // constrained random: small index range to force matches
        for (int i = 0; i < 400; i++) begin
            id_rs1     = 5'($urandom_range(0, 3));
            id_rs2     = 5'($urandom_range(0, 3));
            ex_rs1     = 5'($urandom_range(0, 3));
            ex_rs2     = 5'($urandom_range(0, 3));
            ex_rd      = 5'($urandom_range(0, 3));
            em_rd      = 5'($urandom_range(0, 3));
            mw_rd      = 5'($urandom_range(0, 3));
            ex_rs1_val = 32'h1000_0000 | 32'($urandom_range(0, 65535));
            ex_rs2_val = 32'h2000_0000 | 32'($urandom_range(0, 65535));
            ex_imm     = 32'h3000_0000 | 32'($urandom_range(0, 65535));
            em_res     = 32'h4000_0000 | 32'($urandom_range(0, 65535));
            mw_res     = 32'h5000_0000 | 32'($urandom_range(0, 65535));
            ex_use_imm = 1'($urandom_range(0, 1));
            ex_is_load = 1'($urandom_range(0, 1));
            em_wen     = 1'($urandom_range(0, 1));
            mw_wen     = 1'($urandom_range(0, 1));
            redirect   = ($urandom_range(0, 7) == 0);
            settle();
            full_check("rand");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule